// File: doc/BRIEF.md
# Priority Interrupt Controller With Force

This block collects single-cycle interrupt request pulses on fifteen levels (1 to 15) into a pending register. It also takes a test-mode force register and a software mask, and presents the highest active level to the processor as a registered 4-bit code. Software reaches it through a small register port. It can read the pending, mask, force and control registers. It can write the mask, the force register and the test-enable control bit, and it can drop pending bits through a write-one-to-clear register.

The processor acknowledges a level by pulsing `ack_valid_i` with that level on `ack_level_i`. The acknowledge removes the source that produced the level. That source is the forced bit when test mode is on and the level is forced; otherwise it is the pending bit. Level 15 cannot be masked. A receive overrun reported by either of two serial channels raises level 7. A write that sets bits outside a register's legal field produces a one-cycle parity-error pulse. The legal part of that write is still stored.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A pulse on `irq_req_i[n]`, n from 1 to 15, sets bit n of the pending register (address 0). A pulse on bit 0 has no effect. Pending bit 0 always reads 0.
- R2: A pulse on either bit of `rx_overrun_i` sets pending bit 7.
- R3: The mask register (address 1) stores only bits 14:1 of the write data, so it reads back as the written value AND 0x7FFE. A level whose mask bit is 1 is not presented. Level 15 is presented whatever was written to the mask.
- R4: In the cycle after any register update, `irq_level_o` equals the highest set bit of (pending OR force-if-test) AND NOT mask, taken over bits 15:1. It is 0 when no bit is set. A request pulse therefore reaches the output two clock edges after it is sampled.
- R5: Writing address 2 clears every pending bit whose position is 1 in the write data. Address 2 reads as 0. A request on the same level in the same cycle wins, and the bit stays set.
- R6: The force register (address 3) stores write bits 15:1. Its bits take part in the active set only while test enable (bit 0 of the control register, address 4) is 1. A write to the force register takes precedence over a same-cycle acknowledge.
- R7: An acknowledge of level n clears force bit n if test enable is 1 and force bit n is set, and leaves pending bit n unchanged in that case. Otherwise it clears pending bit n. An acknowledge of level 0 changes nothing.
- R8: `par_err_o` is 1 for exactly the cycle after either of two kinds of write. The first is a write to the mask register with any bit set in 0xFFFF8001. The second is a write to the clear or force register with any bit set in 0xFFFF0001. It is 0 at all other times.
- R9: After reset, every register reads 0, `irq_level_o` is 0 and `par_err_o` is 0. Addresses 5 to 7 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req_i | input | 16 | Single-cycle request pulses, bit n for level n |
| rx_overrun_i | input | 2 | Receive overrun pulses from two serial channels |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| ack_valid_i | input | 1 | Processor acknowledge strobe |
| ack_level_i | input | 4 | Level being acknowledged |
| irq_level_o | output | 4 | Registered highest active level, 0 when none |
| par_err_o | output | 1 | One-cycle pulse after an illegal-bit write |

## Verification
Most internal state is visible through the read port in the cycle after it changes. A pending or force bit that fails to set or clear shows up in the next readback of its register. It also shows up one edge later on `irq_level_o`, provided that bit is the highest active level. A mask register that keeps an illegal bit is easiest to see with level 15 pending, because the output then falls below 15. A lost test-enable state only shows once force bits are set, so the bench drives forced levels both with test mode on and with it off.

// File: rtl/pic_pkg.sv
package pic_pkg;
    // register addresses on the read/write port
    localparam logic [2:0] ADDR_PEND  = 3'd0;
    localparam logic [2:0] ADDR_MASK  = 3'd1;
    localparam logic [2:0] ADDR_CLR   = 3'd2;
    localparam logic [2:0] ADDR_FORCE = 3'd3;
    localparam logic [2:0] ADDR_CTL   = 3'd4;
endpackage

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
    parameter int NUM_LVL = 16,
    localparam int LVL_W  = $clog2(NUM_LVL)
) (
    input  logic [NUM_LVL-1:0] active_i,
    output logic [LVL_W-1:0]   level_o
);
    // ascending scan: the last hit is the highest level; bit 0 never counts
    always_comb begin
        level_o = '0;
        for (int i = 1; i < NUM_LVL; i++) begin
            if (active_i[i]) level_o = LVL_W'(i);
        end
    end
endmodule

// File: rtl/pic_regfile.sv
module pic_regfile
    import pic_pkg::*;
#(
    parameter int NUM_LVL = 16,
    parameter int DATA_W  = 32,
    parameter int OVR_LVL = 7,
    parameter int NUM_OVR = 2,
    localparam int LVL_W  = $clog2(NUM_LVL)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LVL-1:0] req_i,
    input  logic [NUM_OVR-1:0] ovr_i,
    input  logic               we_i,
    input  logic [2:0]         addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    input  logic               ack_valid_i,
    input  logic [LVL_W-1:0]   ack_level_i,
    output logic [NUM_LVL-1:0] pend_o,
    output logic [NUM_LVL-1:0] mask_o,
    output logic [NUM_LVL-1:0] force_o,
    output logic               test_o,
    output logic               par_err_o
);
    localparam logic [DATA_W-1:0] LEG_SRC_W  = DATA_W'((64'd1 << NUM_LVL) - 64'd2);
    localparam logic [DATA_W-1:0] LEG_MASK_W = LEG_SRC_W & ~(DATA_W'(1) << (NUM_LVL - 1));
    localparam logic [NUM_LVL-1:0] LEG_SRC   = LEG_SRC_W[NUM_LVL-1:0];
    localparam logic [NUM_LVL-1:0] LEG_MASK  = LEG_MASK_W[NUM_LVL-1:0];

    typedef struct packed {
        logic [NUM_LVL-1:0] pend;
        logic [NUM_LVL-1:0] mask;
        logic [NUM_LVL-1:0] frc;
        logic               test;
        logic               par;
    } pic_state_t;

    pic_state_t st_d, st_q;
    logic [NUM_LVL-1:0] ack_oh;

    // one-hot acknowledge decode; level 0 never decodes
    for (genvar i = 0; i < NUM_LVL; i++) begin : g_ack
        if (i == 0) begin : g_zero
            assign ack_oh[i] = 1'b0;
        end else begin : g_lvl
            assign ack_oh[i] = ack_valid_i && (ack_level_i == LVL_W'(i));
        end
    end

    always_comb begin
        logic [NUM_LVL-1:0] req_eff, ack_f, ack_p, clr;
        st_d     = st_q;
        st_d.par = 1'b0;
        req_eff  = req_i & LEG_SRC;
        if (|ovr_i) req_eff[OVR_LVL] = 1'b1;
        ack_f    = ack_oh & (st_q.test ? st_q.frc : '0);
        ack_p    = ack_oh & ~ack_f;
        clr      = '0;
        st_d.frc = st_q.frc & ~ack_f;
        if (we_i) begin
            case (addr_i)
                ADDR_MASK: begin
                    st_d.mask = wdata_i[NUM_LVL-1:0] & LEG_MASK;
                    st_d.par  = |(wdata_i & ~LEG_MASK_W);
                end
                ADDR_CLR: begin
                    clr      = wdata_i[NUM_LVL-1:0] & LEG_SRC;
                    st_d.par = |(wdata_i & ~LEG_SRC_W);
                end
                ADDR_FORCE: begin
                    st_d.frc = wdata_i[NUM_LVL-1:0] & LEG_SRC;
                    st_d.par = |(wdata_i & ~LEG_SRC_W);
                end
                ADDR_CTL: st_d.test = wdata_i[0];
                default: ;
            endcase
        end
        st_d.pend = (st_q.pend & ~clr & ~ack_p) | req_eff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (addr_i)
            ADDR_PEND:  rdata_o = DATA_W'(st_q.pend);
            ADDR_MASK:  rdata_o = DATA_W'(st_q.mask);
            ADDR_FORCE: rdata_o = DATA_W'(st_q.frc);
            ADDR_CTL:   rdata_o = DATA_W'(st_q.test);
            default:    rdata_o = '0;
        endcase
    end

    assign pend_o    = st_q.pend;
    assign mask_o    = st_q.mask;
    assign force_o   = st_q.frc;
    assign test_o    = st_q.test;
    assign par_err_o = st_q.par;

    // R1: every legal request bit is pending after the edge
    for (genvar i = 1; i < NUM_LVL; i++) begin : g_req_chk
        p_req_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
            req_i[i] |=> pend_o[i]);
    end

    p_ovr_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|ovr_i) |=> pend_o[OVR_LVL]);

    p_clear_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == ADDR_CLR && (&wdata_i[NUM_LVL-1:1])
         && req_i == '0 && ovr_i == '0) |=> (pend_o == '0));

    p_mask_par_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == ADDR_MASK && |(wdata_i & ~LEG_MASK_W)) |=> par_err_o);

    p_quiet_par_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> !par_err_o);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
    parameter int NUM_LVL = 16,
    parameter int DATA_W  = 32,
    parameter int OVR_LVL = 7,
    parameter int NUM_OVR = 2,
    localparam int LVL_W  = $clog2(NUM_LVL)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LVL-1:0] irq_req_i,
    input  logic [NUM_OVR-1:0] rx_overrun_i,
    input  logic               reg_we_i,
    input  logic [2:0]         reg_addr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    input  logic               ack_valid_i,
    input  logic [LVL_W-1:0]   ack_level_i,
    output logic [LVL_W-1:0]   irq_level_o,
    output logic               par_err_o
);
    localparam logic [NUM_LVL-1:0] LVL_BITS = {{(NUM_LVL-1){1'b1}}, 1'b0};

    logic [NUM_LVL-1:0] pend, mask, frc, active;
    logic               test;
    logic [LVL_W-1:0]   level_d, level_q;

    pic_regfile #(
        .NUM_LVL(NUM_LVL), .DATA_W(DATA_W), .OVR_LVL(OVR_LVL), .NUM_OVR(NUM_OVR)
    ) regs_i (
        .clk(clk), .rst_n(rst_n),
        .req_i(irq_req_i), .ovr_i(rx_overrun_i),
        .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
        .rdata_o(reg_rdata_o),
        .ack_valid_i(ack_valid_i), .ack_level_i(ack_level_i),
        .pend_o(pend), .mask_o(mask), .force_o(frc), .test_o(test),
        .par_err_o(par_err_o)
    );

    always_comb begin
        active = (pend | (test ? frc : '0)) & ~mask & LVL_BITS;
    end

    pic_prio_enc #(.NUM_LVL(NUM_LVL)) enc_i (
        .active_i(active),
        .level_o(level_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= '0;
        else        level_q <= level_d;
    end

    assign irq_level_o = level_q;

    p_top_unmasked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pend[NUM_LVL-1] |=> (irq_level_o == LVL_W'(NUM_LVL - 1)));

    p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~mask & LVL_BITS) == '0 && !test) |=> (irq_level_o == '0));

    p_force_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!test && pend == '0) |=> (irq_level_o == '0));
endmodule

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req = '0;
    logic [1:0]  ovr = '0;
    logic        we = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ack_v = 1'b0;
    logic [3:0]  ack_l = '0;
    logic [3:0]  level;
    logic        perr;

    int checks = 0;
    int errors = 0;

    // bench model state
    logic [15:0] m_pend = '0, m_mask = '0, m_frc = '0;
    logic        m_test = 1'b0;
    logic [3:0]  e_lvl = '0;
    logic        e_par = 1'b0;

    always #2 clk = ~clk;

    prio_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .irq_req_i(req), .rx_overrun_i(ovr),
        .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata),
        .ack_valid_i(ack_v), .ack_level_i(ack_l),
        .irq_level_o(level), .par_err_o(perr)
    );

    function automatic logic [3:0] top_level(input logic [15:0] p, input logic [15:0] m,
                                             input logic [15:0] f, input logic t);
        logic [15:0] act;
        act = (p | (t ? f : 16'h0)) & ~m & 16'hFFFE;
        for (int i = 15; i >= 1; i--) if (act[i]) return 4'(i);
        return 4'd0;
    endfunction

    function automatic logic [31:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0: return {16'h0, m_pend};
            3'd1: return {16'h0, m_mask};
            3'd3: return {16'h0, m_frc};
            3'd4: return {31'h0, m_test};
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        req = '0; ovr = '0; we = 1'b0; wdata = '0; ack_v = 1'b0; ack_l = '0;
    endtask

    // one clock: update the model from the driven inputs, then check at negedge
    task automatic cycle();
        logic [15:0] nxt_pend, clr, ackp, reqe;
        logic [3:0]  nl;
        @(posedge clk);
        nl   = top_level(m_pend, m_mask, m_frc, m_test);
        reqe = req & 16'hFFFE;
        if (ovr != 2'b00) reqe[7] = 1'b1;
        clr  = (we && addr == 3'd2) ? (wdata[15:0] & 16'hFFFE) : 16'h0;
        ackp = '0;
        e_par = we && ((addr == 3'd1 && (wdata & 32'hFFFF8001) != 0) ||
                       ((addr == 3'd2 || addr == 3'd3) && (wdata & 32'hFFFF0001) != 0));
        nxt_pend = m_pend;
        if (ack_v && ack_l != 0) begin
            if (m_test && m_frc[ack_l]) m_frc[ack_l] = 1'b0;
            else ackp[ack_l] = 1'b1;
        end
        m_pend = (nxt_pend & ~clr & ~ackp) | reqe;
        if (we) begin
            if (addr == 3'd1) m_mask = wdata[15:0] & 16'h7FFE;
            if (addr == 3'd3) m_frc  = wdata[15:0] & 16'hFFFE;
            if (addr == 3'd4) m_test = wdata[0];
        end
        e_lvl = nl;
        @(negedge clk);
        check("R4 level", 32'(level), 32'(e_lvl));
        check("R8 par_err", 32'(perr), 32'(e_par));
        case (addr)
            3'd0: check("R1 pending read", rdata, exp_read(addr));
            3'd1: check("R3 mask read", rdata, exp_read(addr));
            3'd3: check("R6 force read", rdata, exp_read(addr));
            default: check("R9 other read", rdata, exp_read(addr));
        endcase
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        we = 1'b1; addr = a; wdata = d;
        cycle();
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd_check(input string tag, input logic [2:0] a, input logic [31:0] exp);
        addr = a;
        #0.1;
        check(tag, rdata, exp);
    endtask

    initial begin
        void'($urandom(32'd7719));
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int a = 0; a < 8; a++) rd_check("R9 reset read", 3'(a), 32'h0);
        check("R9 reset level", 32'(level), 32'h0);
        check("R9 reset par_err", 32'(perr), 32'h0);
        rst_n = 1'b1;
        addr = 3'd0;
        cycle();

        // R1: bit 0 request has no effect
        req = 16'h0001; cycle(); idle_inputs();
        rd_check("R1 bit0 ignored", 3'd0, 32'h0);

        // R4: highest of two requests
        req = 16'h0208; cycle(); idle_inputs(); cycle();
        check("R4 highest of 3,9", 32'(level), 32'd9);
        rd_check("R1 pending 3,9", 3'd0, 32'h208);

        // R3: mask level 9 exposes level 3
        wr(3'd1, 32'h0000_0200); cycle();
        check("R3 masked 9 gives 3", 32'(level), 32'd3);

        // R8/R3: illegal mask bits, level 15 unmaskable
        wr(3'd1, 32'h0000_FFFF);
        check("R8 mask illegal pulse", 32'(perr), 32'd1);
        rd_check("R3 mask keeps 14:1", 3'd1, 32'h7FFE);
        cycle();
        check("R8 pulse one cycle", 32'(perr), 32'd0);
        req = 16'h8000; cycle(); idle_inputs(); cycle();
        check("R3 level 15 unmaskable", 32'(level), 32'd15);

        // R5: clear, and request wins over clear
        wr(3'd2, 32'h0000_FFFE); cycle();
        rd_check("R5 cleared", 3'd0, 32'h0);
        check("R5 level after clear", 32'(level), 32'd0);
        rd_check("R5 clear reads zero", 3'd2, 32'h0);
        req = 16'h0010; wr(3'd2, 32'h0000_0010); idle_inputs();
        rd_check("R5 request beats clear", 3'd0, 32'h10);
        wr(3'd1, 32'h0); wr(3'd2, 32'h0000_FFFE);

        // R2: overrun on channel 1
        ovr = 2'b10; cycle(); idle_inputs(); cycle();
        rd_check("R2 overrun sets 7", 3'd0, 32'h80);
        check("R2 level 7", 32'(level), 32'd7);

        // R6: force ignored without test, used with test
        wr(3'd3, 32'h0000_4000); cycle();
        check("R6 force gated off", 32'(level), 32'd7);
        wr(3'd4, 32'h1); cycle();
        check("R6 force in test", 32'(level), 32'd14);

        // R7: acknowledge prefers the force bit
        req = 16'h4000; cycle(); idle_inputs();
        ack_v = 1'b1; ack_l = 4'd14; cycle(); idle_inputs();
        rd_check("R7 force bit cleared", 3'd3, 32'h0);
        rd_check("R7 pending kept", 3'd0, 32'h4080);
        ack_v = 1'b1; ack_l = 4'd14; cycle(); idle_inputs();
        rd_check("R7 pending cleared", 3'd0, 32'h80);
        ack_v = 1'b1; ack_l = 4'd0; cycle(); idle_inputs();
        rd_check("R7 ack 0 no effect", 3'd0, 32'h80);

        // R8: illegal force bit
        wr(3'd3, 32'h0000_0001);
        check("R8 force illegal pulse", 32'(perr), 32'd1);
        rd_check("R8 legal part stored", 3'd3, 32'h0);

        // random mix
        for (int n = 0; n < 3000; n++) begin
            idle_inputs();
            if ($urandom % 6 == 0) req = 16'($urandom);
            if ($urandom % 20 == 0) ovr = 2'($urandom);
            addr = 3'($urandom % 6);
            if ($urandom % 5 == 0) begin
                we = 1'b1;
                wdata = $urandom & (($urandom % 4 == 0) ? 32'hFFFF_FFFF : 32'h0000_FFFE);
            end
            if ($urandom % 5 == 0) begin
                ack_v = 1'b1; ack_l = 4'($urandom);
            end
            cycle();
        end
        idle_inputs();
        cycle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule